// File: doc/BRIEF.md
# Word FIFO with Byte Packing and Unpacking

This block sits between a 32-bit host data register and a byte-wide card data stream. It keeps a circular FIFO of 32-bit words. A host write to the data port pushes a word. A host read returns the word at the head and pops it.

When data flows from the card, incoming bytes are gathered little-endian into a word. The word is pushed after every fourth byte. If the transfer ends partway through a word, the partial word is pushed with its unused upper bytes set to zero. When data flows to the card, words are popped and sent out low byte first. Each direction of the byte stream uses a valid/ready handshake, and at most one byte moves per clock.

The length of a transfer is set by two writes. The first sets the block size in bytes. The second sets the block count, which loads the remaining byte count as block count times block size. The block reports how many words the FIFO holds and whether the byte count has run out. Toward the card, it also gives a one-cycle pulse at each block boundary.

Top module: `sd_word_fifo`

## Requirements
- R1: After reset the FIFO is empty (`fifo_level` 0, `host_rdata` 0), `rx_ready` and `tx_valid` are low, `blk_done` is low and `xfer_done` is high.
- R2: The FIFO holds DEPTH words and returns them in push order. A push while it holds DEPTH words is dropped, and the stored words and the level are unchanged.
- R3: A pop from an empty FIFO shows `host_rdata` as 0 and leaves `fifo_level` at 0.
- R4: Bytes taken from the card fill a word little-endian: the first byte goes to bits 7:0, the second to 15:8, the third to 23:16 and the fourth to 31:24. The word is pushed when its fourth byte is taken.
- R5: When the remaining count runs out partway through a word, that word is still pushed, with its unfilled upper bytes at zero.
- R6: Toward the card, each popped word is sent low byte first, as bits 7:0, then 15:8, then 23:16, then 31:24.
- R7: A write to `cnt_we` loads the remaining byte count as `cnt_in` times the stored block size, and `xfer_done` falls when the product is nonzero. Each byte handshake lowers the count by one. No byte moves in either direction while the count is zero.
- R8: With `to_card` low, `rx_ready` is low while the FIFO is full.
- R9: With `to_card` high, `tx_valid` is low while the FIFO is empty and no word is partly sent.
- R10: With `to_card` high, `blk_irq_en` high and a nonzero block size, `blk_done` is high for one cycle after each byte handshake that leaves the remaining count a multiple of the block size. It is never high otherwise.
- R11: `fifo_level` gives the number of stored words and changes in the cycle after a push or a pop.
- R12: `xfer_done` is high exactly when the remaining byte count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Push `host_wdata` into the FIFO |
| host_wdata | input | 32 | Word written by the host |
| host_rd | input | 1 | Pop the head word |
| host_rdata | output | 32 | Head word, or 0 when empty |
| size_we | input | 1 | Store `size_in` as the block size |
| size_in | input | SZ_W | Block size in bytes |
| cnt_we | input | 1 | Load the remaining count from `cnt_in` and the block size |
| cnt_in | input | CNT_W | Number of blocks |
| to_card | input | 1 | 1: host to card, 0: card to host |
| blk_irq_en | input | 1 | Enables block-boundary pulses |
| rx_valid | input | 1 | Card byte available |
| rx_data | input | 8 | Card byte |
| rx_ready | output | 1 | Block accepts the card byte |
| tx_valid | output | 1 | Byte toward the card available |
| tx_data | output | 8 | Byte toward the card |
| tx_ready | input | 1 | Card accepts the byte |
| fifo_level | output | $clog2(DEPTH)+1 | Words held in the FIFO |
| blk_done | output | 1 | Block boundary pulse |
| xfer_done | output | 1 | Remaining byte count is zero |

## Verification
The bench builds the block with a depth of 4 words, an 8-bit block size and a 4-bit block count. The shallow FIFO lets a card-side stream of 20 bytes fill it, so the backpressure on `rx_ready` and the dropped fifth host push can both be seen in a few cycles. The small size field keeps the count products short. Then a partial final word and two block boundaries on the card-bound path both appear within a single test.

// File: rtl/sdwf_pkg.sv
package sdwf_pkg;

    typedef logic [7:0]  byte_t;
    typedef logic [31:0] word_t;

    // gathering state for bytes arriving from the card
    typedef struct packed {
        logic [1:0] idx;
        word_t      acc;
    } pack_t;

    // draining state for bytes leaving toward the card
    typedef struct packed {
        logic [1:0] left;
        word_t      sh;
    } unpack_t;

    // place one byte into lane idx of a word, lane 0 being bits 7:0
    function automatic word_t lane_insert(word_t acc, logic [1:0] idx, byte_t b);
        word_t r;
        r = acc;
        r[idx*8 +: 8] = b;
        return r;
    endfunction

endpackage

// File: rtl/sdwf_ring.sv
module sdwf_ring #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  sdwf_pkg::word_t            push_data,
    input  logic                       pop,
    output sdwf_pkg::word_t            head,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       full,
    output logic                       empty
);
    import sdwf_pkg::*;

    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = PTR_W + 1;

    word_t             mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_ptr;
    logic [LVL_W-1:0]  cnt;
    logic              do_push;
    logic              do_pop;

    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == LVL_W'(DEPTH));
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        head    = empty ? '0 : mem[rd_ptr];
        level   = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/sdwf_pack.sv
module sdwf_pack (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             active,
    input  logic             fifo_full,
    input  logic             last_byte,
    input  logic             rx_valid,
    input  sdwf_pkg::byte_t  rx_data,
    output logic             rx_ready,
    output logic             take,
    output logic             push,
    output sdwf_pkg::word_t  push_word
);
    import sdwf_pkg::*;

    pack_t st;

    always_comb begin
        rx_ready  = active && !fifo_full;
        take      = rx_valid && rx_ready;
        push_word = lane_insert(st.acc, st.idx, rx_data);
        push      = take && ((st.idx == 2'd3) || last_byte);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st <= '0;
        end else if (take) begin
            if (push) begin
                st <= '0;
            end else begin
                st.acc <= push_word;
                st.idx <= st.idx + 2'd1;
            end
        end
    end

endmodule

// File: rtl/sdwf_unpack.sv
module sdwf_unpack (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             active,
    input  logic             fifo_empty,
    input  sdwf_pkg::word_t  head_word,
    input  logic             tx_ready,
    output logic             tx_valid,
    output sdwf_pkg::byte_t  tx_data,
    output logic             take,
    output logic             pop
);
    import sdwf_pkg::*;

    unpack_t st;
    logic    mid_word;

    always_comb begin
        mid_word = (st.left != 2'd0);
        tx_valid = active && (mid_word || !fifo_empty);
        tx_data  = mid_word ? st.sh[7:0] : head_word[7:0];
        take     = tx_valid && tx_ready;
        pop      = take && !mid_word;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st <= '0;
        end else if (take) begin
            if (mid_word) begin
                st.sh   <= st.sh >> 8;
                st.left <= st.left - 2'd1;
            end else begin
                st.sh   <= head_word >> 8;
                st.left <= 2'd3;
            end
        end
    end

endmodule

// File: rtl/sdwf_count.sv
module sdwf_count #(
    parameter int SZ_W  = 12,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             size_we,
    input  logic [SZ_W-1:0]  size_in,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             step,
    input  logic             blk_arm,
    input  logic             blk_en,
    output logic             last_byte,
    output logic             done,
    output logic             blk_done
);
    localparam int REM_W = SZ_W + CNT_W;

    logic [SZ_W-1:0]  bsize;
    logic [SZ_W-1:0]  blk_left;
    logic [REM_W-1:0] rem;
    logic             boundary;

    always_comb begin
        done      = (rem == '0);
        last_byte = (rem == REM_W'(1));
        boundary  = (blk_left == SZ_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bsize    <= '0;
            blk_left <= '0;
            rem      <= '0;
            blk_done <= 1'b0;
        end else begin
            blk_done <= step && !done && blk_arm && blk_en
                        && (bsize != '0) && boundary;
            if (size_we) bsize <= size_in;
            if (cnt_we) begin
                rem      <= REM_W'(cnt_in) * REM_W'(bsize);
                blk_left <= bsize;
            end else if (step && !done) begin
                rem <= rem - 1'b1;
                if (blk_left <= SZ_W'(1)) blk_left <= bsize;
                else                       blk_left <= blk_left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/sd_word_fifo.sv
module sd_word_fifo #(
    parameter int DEPTH = 16,
    parameter int SZ_W  = 12,
    parameter int CNT_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_wr,
    input  logic [31:0]             host_wdata,
    input  logic                    host_rd,
    output logic [31:0]             host_rdata,
    input  logic                    size_we,
    input  logic [SZ_W-1:0]         size_in,
    input  logic                    cnt_we,
    input  logic [CNT_W-1:0]        cnt_in,
    input  logic                    to_card,
    input  logic                    blk_irq_en,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_data,
    output logic                    rx_ready,
    output logic                    tx_valid,
    output logic [7:0]              tx_data,
    input  logic                    tx_ready,
    output logic [$clog2(DEPTH):0]  fifo_level,
    output logic                    blk_done,
    output logic                    xfer_done
);
    import sdwf_pkg::*;

    word_t head;
    word_t pk_word;
    word_t push_data;
    logic  full, empty;
    logic  pk_take, pk_push;
    logic  up_take, up_pop;
    logic  last_byte, done;
    logic  push, pop, step;

    always_comb begin
        push       = pk_push || host_wr;
        push_data  = pk_push ? pk_word : host_wdata;
        pop        = up_pop || host_rd;
        step       = pk_take || up_take;
        host_rdata = head;
        xfer_done  = done;
    end

    sdwf_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst(rst),
        .push(push), .push_data(push_data), .pop(pop),
        .head(head), .level(fifo_level), .full(full), .empty(empty)
    );

    sdwf_pack u_pack (
        .clk(clk), .rst(rst), .restart(cnt_we),
        .active(!to_card && !done), .fifo_full(full), .last_byte(last_byte),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .take(pk_take), .push(pk_push), .push_word(pk_word)
    );

    sdwf_unpack u_unpack (
        .clk(clk), .rst(rst), .restart(cnt_we),
        .active(to_card && !done), .fifo_empty(empty), .head_word(head),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .take(up_take), .pop(up_pop)
    );

    sdwf_count #(.SZ_W(SZ_W), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst),
        .size_we(size_we), .size_in(size_in),
        .cnt_we(cnt_we), .cnt_in(cnt_in),
        .step(step), .blk_arm(to_card), .blk_en(blk_irq_en),
        .last_byte(last_byte), .done(done), .blk_done(blk_done)
    );

endmodule

// File: rtl/sd_word_fifo_chk.sv
module sd_word_fifo_chk #(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic [31:0]            host_rdata,
    input logic                   rx_ready,
    input logic                   tx_valid,
    input logic                   tx_ready,
    input logic                   to_card,
    input logic [$clog2(DEPTH):0] fifo_level,
    input logic                   blk_done,
    input logic                   xfer_done
);
    localparam int LVL_W = $clog2(DEPTH) + 1;

    p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LVL_W'(DEPTH));

    p_empty_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == '0) |-> (host_rdata == 32'd0));

    p_idle_no_move_r7: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> (!rx_ready && !tx_valid));

    p_full_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == LVL_W'(DEPTH)) |-> !rx_ready);

    p_dir_tx_r9: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> to_card);

    p_blk_after_byte_r10: assert property (@(posedge clk) disable iff (rst)
        blk_done |-> $past(tx_valid && tx_ready));

    p_level_step_r11: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == $past(fifo_level)) ||
        (fifo_level == $past(fifo_level) + 1'b1) ||
        (fifo_level == $past(fifo_level) - 1'b1));

endmodule

bind sd_word_fifo sd_word_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .host_rdata(host_rdata), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .to_card(to_card),
    .fifo_level(fifo_level), .blk_done(blk_done), .xfer_done(xfer_done)
);

// File: tb/test_sd_word_fifo.sv
module test_sd_word_fifo;
    localparam int DEPTH = 4;
    localparam int SZ_W  = 8;
    localparam int CNT_W = 4;
    localparam int LVL_W = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             host_wr = 1'b0, host_rd = 1'b0;
    logic [31:0]      host_wdata = '0, host_rdata;
    logic             size_we = 1'b0, cnt_we = 1'b0;
    logic [SZ_W-1:0]  size_in = '0;
    logic [CNT_W-1:0] cnt_in = '0;
    logic             to_card = 1'b0, blk_irq_en = 1'b0;
    logic             rx_valid = 1'b0, rx_ready;
    logic [7:0]       rx_data = '0, tx_data;
    logic             tx_valid, tx_ready = 1'b0;
    logic [LVL_W-1:0] fifo_level;
    logic             blk_done, xfer_done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sd_word_fifo #(.DEPTH(DEPTH), .SZ_W(SZ_W), .CNT_W(CNT_W)) i_sd_word_fifo (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_word(input logic [31:0] w);
        host_wr = 1'b1; host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic pop_word(output logic [31:0] w);
        #1 w = host_rdata;
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic load(input int sz, input int nblk);
        size_we = 1'b1; size_in = SZ_W'(sz);
        @(negedge clk);
        size_we = 1'b0; cnt_we = 1'b1; cnt_in = CNT_W'(nblk);
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        rx_valid = 1'b1; rx_data = b;
        #1 chk(req, 32'(rx_ready), 32'd1);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 level", 32'(fifo_level), 32'd0);
        chk("R1 rdata", host_rdata, 32'd0);
        chk("R1 rx_ready", 32'(rx_ready), 32'd0);
        chk("R1 tx_valid", 32'(tx_valid), 32'd0);
        chk("R1 blk_done", 32'(blk_done), 32'd0);
        chk("R1 xfer_done", 32'(xfer_done), 32'd1);
    endtask

    task automatic t_host_fifo;
        logic [31:0] w;
        for (int i = 0; i < DEPTH + 1; i++) push_word(32'h1000_0000 + 32'(i));
        chk("R2 R11 level after overfill", 32'(fifo_level), DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            pop_word(w);
            chk("R2 order", w, 32'h1000_0000 + 32'(i));
        end
        chk("R11 level drained", 32'(fifo_level), 32'd0);
        pop_word(w);
        chk("R3 empty pop data", w, 32'd0);
        chk("R3 empty pop level", 32'(fifo_level), 32'd0);
    endtask

    task automatic t_pack;
        logic [31:0] w;
        to_card = 1'b0;
        load(6, 1);
        chk("R7 done low after load", 32'(xfer_done), 32'd0);
        send_byte(8'h11, "R4 ready"); send_byte(8'h22, "R4 ready");
        send_byte(8'h33, "R4 ready");
        chk("R4 no push before 4th byte", 32'(fifo_level), 32'd0);
        send_byte(8'h44, "R4 ready");
        chk("R4 R11 push on 4th byte", 32'(fifo_level), 32'd1);
        send_byte(8'h55, "R5 ready"); send_byte(8'h66, "R5 ready");
        chk("R5 partial pushed", 32'(fifo_level), 32'd2);
        chk("R12 done at zero", 32'(xfer_done), 32'd1);
        rx_valid = 1'b1; rx_data = 8'h77;
        #1 chk("R7 no byte when count zero", 32'(rx_ready), 32'd0);
        @(negedge clk); rx_valid = 1'b0;
        chk("R7 level unchanged", 32'(fifo_level), 32'd2);
        pop_word(w); chk("R4 little-endian word", w, 32'h4433_2211);
        pop_word(w); chk("R5 zero padded", w, 32'h0000_6655);
    endtask

    task automatic t_backpressure;
        logic [31:0] w;
        to_card = 1'b0;
        load(4, 5);
        for (int i = 0; i < 4 * DEPTH; i++) send_byte(8'(i), "R8 ready before full");
        rx_valid = 1'b1;
        #1 chk("R8 stall when full", 32'(rx_ready), 32'd0);
        chk("R8 level full", 32'(fifo_level), DEPTH);
        rx_valid = 1'b0;
        pop_word(w);
        chk("R8 first word", w, 32'h0302_0100);
        #1 chk("R8 resumes", 32'(rx_ready), 32'd1);
        for (int i = 1; i < DEPTH; i++) pop_word(w);
        chk("R11 drained", 32'(fifo_level), 32'd0);
    endtask

    task automatic t_unpack;
        logic [7:0] exp [8];
        int blk_seen;
        exp = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hB0, 8'hB1, 8'hB2, 8'hB3};
        blk_seen = 0;
        to_card = 1'b1; blk_irq_en = 1'b1;
        load(4, 2);
        #1 chk("R9 idle when empty", 32'(tx_valid), 32'd0);
        push_word(32'hA3A2_A1A0);
        push_word(32'hB3B2_B1B0);
        for (int i = 0; i < 8; i++) begin
            tx_ready = 1'b1;
            #1 chk("R6 valid", 32'(tx_valid), 32'd1);
            chk("R6 byte order", 32'(tx_data), 32'(exp[i]));
            @(negedge clk);
            tx_ready = 1'b0;
            chk("R10 pulse at boundary", 32'(blk_done), (i == 3 || i == 7) ? 32'd1 : 32'd0);
            if (blk_done) blk_seen++;
        end
        chk("R10 two pulses", 32'(blk_seen), 32'd2);
        @(negedge clk);
        chk("R10 pulse one cycle", 32'(blk_done), 32'd0);
        chk("R12 done", 32'(xfer_done), 32'd1);
        chk("R9 no valid at end", 32'(tx_valid), 32'd0);
        blk_irq_en = 1'b0; to_card = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_host_fifo();
        t_pack();
        t_backpressure();
        t_unpack();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule